// File: doc/BRIEF.md
# Indexed Host Interrupt Enable Gate

This block decides whether each of two host interrupt lines reaches the processor: a fast interrupt line and a normal interrupt line. Each line has a raw pending input and an enable bit. The gated output is the registered AND of the two. Software never writes the enable bits directly. It writes a host index to a set address to enable one line, or to a clear address to disable one line. No read-modify-write is needed, and the other line is never disturbed.

A set write aimed at a line that is already enabled does not act as a no-op. It re-fires that line. For one cycle the output is forced low, and it then returns high if the pending input is still active. An edge-sensitive receiver therefore sees a fresh event.

The block sits on a simple synchronous register bus with address, write strobe, write data, read strobe and registered read data. A read-only status address exposes the two enable bits.

Top module: `host_irq_gate`

## Requirements
- R1: After reset both enables are 0, both host outputs are 0 and the read data is 0.
- R2: A write to the set address (default 0x00) uses only bit 0 of the write data as the index (0 = fast line, 1 = normal line). It sets that line's enable and leaves the other enable unchanged. Bits 31:1 are ignored.
- R3: A write to the clear address (default 0x04) uses only bit 0 of the write data as the index. It clears that line's enable and leaves the other enable unchanged. Bits 31:1 are ignored.
- R4: Each host output equals its enable AND its pending input, registered one cycle after the enable takes effect. A pending input that is low or disabled keeps its output low.
- R5: A set write to an already-enabled line with its pending input high drives that output low for exactly one cycle, in the second cycle after the write. The output is high again in the third cycle. A set write to a disabled line raises the output without a low gap. A set write to an enabled line whose pending input is low leaves the output low.
- R6: A read of the set or clear address returns all zeros, with the read data registered one cycle after the read strobe.
- R7: A read of the status address (default 0x08) returns the fast-line enable in bit 0 and the normal-line enable in bit 1, with bits 31:2 zero.
- R8: A write to the status address or to any unmapped address leaves both enables and both outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data, bit 0 is the host index |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| pend_fiq_i | input | 1 | Raw pending input for the fast line |
| pend_irq_i | input | 1 | Raw pending input for the normal line |
| host_fiq_o | output | 1 | Gated fast interrupt output |
| host_irq_o | output | 1 | Gated normal interrupt output |

## Verification
A write is sampled at one edge and changes the enable at that same edge. The gated output follows at the next edge, so outputs are checked two falling edges after the write strobe is dropped. Read data appears at the edge that samples the read strobe and is checked at the falling edge that ends the read. A retrigger is observed on three consecutive falling edges after a set write: high, then low, then high. The bench checks the output at each of those three edges, so a gap that comes early, comes late or runs long is reported.

// File: rtl/host_irq_gate_pkg.sv
package host_irq_gate_pkg;

    localparam int NUM_HOST = 2;
    localparam int IDX_W    = (NUM_HOST > 1) ? $clog2(NUM_HOST) : 1;

    typedef enum logic [IDX_W-1:0] {
        HOST_FAST   = 1'b0,
        HOST_NORMAL = 1'b1
    } host_sel_e;

    typedef struct packed {
        logic [NUM_HOST-1:0] en;
        logic [NUM_HOST-1:0] refire;
    } gate_state_t;

endpackage

// File: rtl/hig_bus_decode.sv
module hig_bus_decode
    import host_irq_gate_pkg::*;
#(
    parameter int              ADDR_W    = 8,
    parameter int              DATA_W    = 32,
    parameter logic [ADDR_W-1:0] SET_ADDR  = 8'h00,
    parameter logic [ADDR_W-1:0] CLR_ADDR  = 8'h04,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h08
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [DATA_W-1:0]   bus_wdata,
    input  logic                bus_rd,
    input  logic [NUM_HOST-1:0] en_q,
    output logic [NUM_HOST-1:0] set_vec,
    output logic [NUM_HOST-1:0] clr_vec,
    output logic [DATA_W-1:0]   rdata
);

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } rd_state_t;

    rd_state_t rd_d, rd_q;

    logic [IDX_W-1:0] idx;
    logic             hit_set, hit_clr;
    logic             unused_wdata;

    assign idx          = bus_wdata[IDX_W-1:0];
    assign unused_wdata = ^bus_wdata[DATA_W-1:IDX_W];
    assign hit_set      = bus_wr && (bus_addr == SET_ADDR);
    assign hit_clr      = bus_wr && (bus_addr == CLR_ADDR);

    for (genvar h = 0; h < NUM_HOST; h++) begin : g_sel
        assign set_vec[h] = hit_set && (idx == IDX_W'(h));
        assign clr_vec[h] = hit_clr && (idx == IDX_W'(h));
    end

    always_comb begin
        rd_d = '0;
        if (bus_rd && (bus_addr == STAT_ADDR)) begin
            rd_d.rdata[NUM_HOST-1:0] = en_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rdata = rd_q.rdata;

endmodule

// File: rtl/hig_enable_bank.sv
module hig_enable_bank
    import host_irq_gate_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_HOST-1:0] set_vec,
    input  logic [NUM_HOST-1:0] clr_vec,
    output logic [NUM_HOST-1:0] en_q,
    output logic [NUM_HOST-1:0] refire_q
);

    gate_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int h = 0; h < NUM_HOST; h++) begin
            // clear beats set on the same line
            st_d.en[h]     = (st_q.en[h] | set_vec[h]) & ~clr_vec[h];
            st_d.refire[h] = set_vec[h] & st_q.en[h] & ~clr_vec[h];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_q     = st_q.en;
    assign refire_q = st_q.refire;

endmodule

// File: rtl/hig_out_lane.sv
module hig_out_lane (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic refire,
    input  logic pend,
    output logic host_o
);

    logic out_d, out_q;

    always_comb begin
        out_d = en & pend & ~refire;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= 1'b0;
        end else begin
            out_q <= out_d;
        end
    end

    assign host_o = out_q;

endmodule

// File: rtl/host_irq_gate.sv
module host_irq_gate
    import host_irq_gate_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter int                DATA_W    = 32,
    parameter logic [ADDR_W-1:0] SET_ADDR  = 8'h00,
    parameter logic [ADDR_W-1:0] CLR_ADDR  = 8'h04,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h08
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              pend_fiq_i,
    input  logic              pend_irq_i,
    output logic              host_fiq_o,
    output logic              host_irq_o
);

    logic [NUM_HOST-1:0] set_vec, clr_vec, en_q, refire_q, pend, host_out;

    assign pend[HOST_FAST]   = pend_fiq_i;
    assign pend[HOST_NORMAL] = pend_irq_i;

    hig_bus_decode #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .SET_ADDR (SET_ADDR),
        .CLR_ADDR (CLR_ADDR),
        .STAT_ADDR(STAT_ADDR)
    ) u_decode (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_wdata(bus_wdata),
        .bus_rd   (bus_rd),
        .en_q     (en_q),
        .set_vec  (set_vec),
        .clr_vec  (clr_vec),
        .rdata    (bus_rdata)
    );

    hig_enable_bank u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .en_q    (en_q),
        .refire_q(refire_q)
    );

    for (genvar h = 0; h < NUM_HOST; h++) begin : g_lane
        hig_out_lane u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (en_q[h]),
            .refire(refire_q[h]),
            .pend  (pend[h]),
            .host_o(host_out[h])
        );
    end

    assign host_fiq_o = host_out[HOST_FAST];
    assign host_irq_o = host_out[HOST_NORMAL];

endmodule

// File: rtl/hig_checker.sv
module hig_checker #(
    parameter int                ADDR_W    = 8,
    parameter int                DATA_W    = 32,
    parameter logic [ADDR_W-1:0] SET_ADDR  = 8'h00,
    parameter logic [ADDR_W-1:0] CLR_ADDR  = 8'h04
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              wr_idx,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              pend_fiq_i,
    input logic              pend_irq_i,
    input logic              host_fiq_o,
    input logic              host_irq_o,
    input logic [1:0]        en_q
);

    logic set_fast, set_norm, clr_fast, clr_norm;
    assign set_fast = bus_wr && bus_addr == SET_ADDR && !wr_idx;
    assign set_norm = bus_wr && bus_addr == SET_ADDR &&  wr_idx;
    assign clr_fast = bus_wr && bus_addr == CLR_ADDR && !wr_idx;
    assign clr_norm = bus_wr && bus_addr == CLR_ADDR &&  wr_idx;

    // R4
    fast_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_fiq_o |-> $past(pend_fiq_i));

    // R4
    norm_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq_o |-> $past(pend_irq_i));

    // R2
    set_norm_enables_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_norm |=> en_q[1]);

    // R3
    clr_fast_disables_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_fast |=> !en_q[0] ##1 !host_fiq_o);

    // R3
    clr_norm_keeps_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_norm && !set_fast) |=> en_q[0] == $past(en_q[0]));

    // R5
    refire_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_fast && en_q[0]) |=> ##1 !host_fiq_o);

    // R6
    idx_regs_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (bus_addr == SET_ADDR || bus_addr == CLR_ADDR)) |=> bus_rdata == '0);

    // R7
    status_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DATA_W-1:2] == '0);

endmodule

bind host_irq_gate hig_checker #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .SET_ADDR(SET_ADDR),
    .CLR_ADDR(CLR_ADDR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .wr_idx    (bus_wdata[0]),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .pend_fiq_i(pend_fiq_i),
    .pend_irq_i(pend_irq_i),
    .host_fiq_o(host_fiq_o),
    .host_irq_o(host_irq_o),
    .en_q      (en_q)
);

// File: tb/test_host_irq_gate.sv
`timescale 1ns/1ps
module test_host_irq_gate;

    localparam logic [7:0] A_SET  = 8'h00;
    localparam logic [7:0] A_CLR  = 8'h04;
    localparam logic [7:0] A_STAT = 8'h08;
    localparam logic [7:0] A_NONE = 8'h0C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        pend_fiq_i = 1'b0;
    logic        pend_irq_i = 1'b0;
    logic        host_fiq_o, host_irq_o;

    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    host_irq_gate i_host_irq_gate (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .pend_fiq_i(pend_fiq_i), .pend_irq_i(pend_irq_i),
        .host_fiq_o(host_fiq_o), .host_irq_o(host_irq_o)
    );

    // op: 0 none, 1 set, 2 clear, 3 write to status, | wdata | pend{irq,fiq} | exp_en | exp_out
    localparam int NV = 10;
    localparam logic [39:0] VECS [0:NV-1] = '{
        {2'd1, 32'h0000_0000, 2'b11, 2'b01, 2'b01},
        {2'd1, 32'h0000_0001, 2'b11, 2'b11, 2'b11},
        {2'd2, 32'h0000_0000, 2'b11, 2'b10, 2'b10},
        {2'd3, 32'h0000_0001, 2'b11, 2'b10, 2'b10},
        {2'd1, 32'hFFFF_FFFE, 2'b11, 2'b11, 2'b11},
        {2'd0, 32'h0000_0000, 2'b01, 2'b11, 2'b01},
        {2'd2, 32'hFFFF_FFFF, 2'b01, 2'b01, 2'b01},
        {2'd2, 32'h0000_0000, 2'b00, 2'b00, 2'b00},
        {2'd1, 32'h0000_0001, 2'b10, 2'b10, 2'b10},
        {2'd3, 32'h0000_0003, 2'b11, 2'b10, 2'b10}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        pend_fiq_i = 1'b1; pend_irq_i = 1'b1;
        @(negedge clk);
        // R1 reset state held while reset is active
        check("R1 outputs in reset", {30'd0, host_irq_o, host_fiq_o}, 32'd0);
        check("R1 rdata in reset", bus_rdata, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 outputs after reset", {30'd0, host_irq_o, host_fiq_o}, 32'd0);
        rd(A_STAT, r);
        check("R1 enables after reset", r, 32'd0);

        // vector walk: R2 R3 R4 R7 R8
        for (int v = 0; v < NV; v++) begin
            logic [1:0] op;
            logic [31:0] d;
            op = VECS[v][39:38];
            d  = VECS[v][37:6];
            pend_irq_i = VECS[v][5];
            pend_fiq_i = VECS[v][4];
            case (op)
                2'd1: wr(A_SET, d);
                2'd2: wr(A_CLR, d);
                2'd3: wr(A_STAT, d);
                default: @(negedge clk);
            endcase
            repeat (2) @(negedge clk);
            check($sformatf("R4 outputs vec %0d", v), {30'd0, host_irq_o, host_fiq_o},
                  {30'd0, VECS[v][1:0]});
            rd(A_STAT, r);
            check($sformatf("R2 R3 R7 R8 status vec %0d", v), r, {30'd0, VECS[v][3:2]});
        end

        // R8 write to unmapped address
        wr(A_NONE, 32'h0000_0001);
        repeat (2) @(negedge clk);
        rd(A_STAT, r);
        check("R8 unmapped write", r, 32'h2);

        // R6 indexed registers read as zero even with enables set
        wr(A_SET, 32'h0);
        rd(A_SET, r);
        check("R6 read set address", r, 32'd0);
        rd(A_CLR, r);
        check("R6 read clear address", r, 32'd0);

        // R5 re-fire of enabled fast line with pending high
        pend_fiq_i = 1'b1; pend_irq_i = 1'b1;
        repeat (3) @(negedge clk);
        check("R5 fast high before refire", {31'd0, host_fiq_o}, 32'd1);
        wr(A_SET, 32'h0);
        check("R5 refire cycle 1", {30'd0, host_irq_o, host_fiq_o}, 32'd3);
        @(negedge clk);
        check("R5 refire cycle 2 gap", {30'd0, host_irq_o, host_fiq_o}, 32'd2);
        @(negedge clk);
        check("R5 refire cycle 3", {30'd0, host_irq_o, host_fiq_o}, 32'd3);
        @(negedge clk);
        check("R5 refire cycle 4", {31'd0, host_fiq_o}, 32'd1);

        // R5 set of disabled line rises without gap
        wr(A_CLR, 32'h1);
        repeat (2) @(negedge clk);
        check("R5 normal cleared", {31'd0, host_irq_o}, 32'd0);
        wr(A_SET, 32'h1);
        check("R5 fresh set cycle 1", {31'd0, host_irq_o}, 32'd0);
        @(negedge clk);
        check("R5 fresh set cycle 2", {31'd0, host_irq_o}, 32'd1);
        @(negedge clk);
        check("R5 fresh set cycle 3", {31'd0, host_irq_o}, 32'd1);

        // R5 re-fire with pending low keeps output low
        pend_irq_i = 1'b0;
        repeat (2) @(negedge clk);
        wr(A_SET, 32'h1);
        for (int k = 0; k < 3; k++) begin
            check($sformatf("R5 refire pend low step %0d", k), {31'd0, host_irq_o}, 32'd0);
            @(negedge clk);
        end

        // R1 reset mid-run clears enables
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 outputs after second reset", {30'd0, host_irq_o, host_fiq_o}, 32'd0);
        rd(A_STAT, r);
        check("R1 enables after second reset", r, 32'd0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule